// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus fetch port and an instruction decoder. While the bus is otherwise idle and at least two byte slots are free, it requests the next 16-bit code word. It fetches at most one word at a time. Returned bytes are appended to a six-entry, byte-wide circular store. The decoder sees the oldest byte together with a valid flag, and takes it by pulsing a read strobe. The strobe carries a marker that says whether the byte starts a new opcode.

Every cycle the block drives a two-bit status code. The code tells an external observer whether the queue did nothing, handed out the first byte of an opcode, handed out a later byte of the same instruction, or was emptied. A taken jump or call pulses the flush input with a new 16-bit target offset. The flush discards all queued bytes and moves the fetch offset to the target. It also marks any word still in flight, so that the word is thrown away when it arrives. An odd target keeps only the upper byte of its first word.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`rd_valid_o`=0), `qs_o` is 00, and the fetch offset equals parameter `RESET_ADDR` (default 0).
- R2: `fetch_req_o` is high exactly when `bus_idle_i` is high, no fetch is in flight, at least two entries are free and `flush_i` is low. `fetch_addr_o` is the fetch offset with bit 0 cleared. A request is accepted in a cycle where `fetch_ack_i` is also high.
- R3: The queue never holds more than `DEPTH` (6) bytes. Once fewer than two entries are free, no request is made.
- R4: Bytes leave in arrival order. For a word fetched at an even offset, bits [7:0] (the even byte) enter the queue before bits [15:8].
- R5: When the fetch offset is odd, a returned word contributes only bits [15:8] and the offset advances by 1. Otherwise it contributes both bytes and the offset advances by 2.
- R6: `qs_o` encodes each cycle as follows: 00 = no queue activity; 01 = a byte was taken with `rd_first_i`=1; 11 = a byte was taken with `rd_first_i`=0; 10 = the queue was flushed.
- R7: When `flush_i` and `rd_i` are high in the same cycle, the flush wins: `qs_o`=10, no byte counts as read, the queue is empty in the next cycle and the fetch offset becomes `flush_addr_i`.
- R8: A word that was in flight when a flush occurred is discarded when it returns, including a return in the flush cycle itself. Only later fetches fill the queue.
- R9: A read strobe while the queue is empty is ignored: `qs_o` stays 00 and the queue contents do not change.
- R10: At most one fetch is in flight. After an accepted request, `fetch_req_o` stays low until `fetch_rvalid_i` returns the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Discard queue and restart fetching (taken branch) |
| flush_addr_i | input | 16 | New fetch offset applied on flush |
| bus_idle_i | input | 1 | The execution side is not using the bus this cycle |
| fetch_req_o | output | 1 | Request for one code word |
| fetch_addr_o | output | 16 | Even offset of the requested word |
| fetch_ack_i | input | 1 | Bus accepts the request this cycle |
| fetch_rvalid_i | input | 1 | Requested word is returned this cycle |
| fetch_rdata_i | input | 16 | Returned word, even byte in bits [7:0] |
| rd_i | input | 1 | Decoder takes the head byte |
| rd_first_i | input | 1 | The byte taken begins a new opcode |
| rd_valid_o | output | 1 | Queue is not empty |
| rd_data_o | output | 8 | Oldest queued byte |
| qs_o | output | 2 | Queue status code for this cycle |

## Verification
The hardest case to reach is a flush that lands while a word is in flight, above all when that word returns in the flush cycle itself or one cycle later. Free-running stimulus rarely lines these events up. The bench therefore has a bus model whose return latency can be set. A directed sequence fixes a long latency, issues a flush immediately after acceptance, and checks that the late word leaves the queue empty. A long random phase then mixes latencies of 0 to 2 cycles with frequent flushes to odd and even targets, and a behavioural queue model is compared with the outputs on every cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   typedef enum logic [1:0] {
      QS_IDLE  = 2'b00,
      QS_FIRST = 2'b01,
      QS_FLUSH = 2'b10,
      QS_NEXT  = 2'b11
   } qs_e;

   localparam int unsigned WORD_W  = 16;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned LANES   = WORD_W / BYTE_W;

endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
   parameter int unsigned DEPTH = 6,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush_i,
   input  logic          pop_i,
   input  logic [1:0]    wr_n_i,
   input  logic [7:0]    wr_b0_i,
   input  logic [7:0]    wr_b1_i,
   output logic [CW-1:0] count_o,
   output logic          pop_ok_o,
   output logic [7:0]    head_o
);

   localparam bit         POW2 = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] head_q, tail_q;
   logic [PW-1:0] head_nx, tail_p1, tail_p2;
   logic [CW-1:0] count_q;
   logic          we0, we1;

   initial begin
      assert (DEPTH >= 2) else $error("pfq_store: DEPTH must be at least 2");
   end

   // pointer advance: natural wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_pow2
         assign head_nx = head_q + PW'(1);
         assign tail_p1 = tail_q + PW'(1);
         assign tail_p2 = tail_q + PW'(2);
      end else begin : g_wrap_cmp
         assign head_nx = (head_q == LAST) ? '0 : head_q + PW'(1);
         assign tail_p1 = (tail_q == LAST) ? '0 : tail_q + PW'(1);
         assign tail_p2 = (tail_p1 == LAST) ? '0 : tail_p1 + PW'(1);
      end
   endgenerate

   assign pop_ok_o = pop_i && (count_q != '0) && !flush_i;
   assign we0      = !flush_i && (wr_n_i != 2'd0);
   assign we1      = !flush_i && (wr_n_i == 2'd2);
   assign count_o  = count_q;
   assign head_o   = mem[head_q];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk) begin
            if (we0 && tail_q == PW'(i)) begin
               mem[i] <= wr_b0_i;
            end else if (we1 && tail_p1 == PW'(i)) begin
               mem[i] <= wr_b1_i;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || flush_i) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (pop_ok_o) begin
            head_q <= head_nx;
         end
         if (we1) begin
            tail_q <= tail_p2;
         end else if (we0) begin
            tail_q <= tail_p1;
         end
         count_q <= count_q + CW'(wr_n_i) - CW'(pop_ok_o);
      end
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      count_q <= CW'(DEPTH));

   a_r9_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
      (pop_i && count_q == '0 && wr_n_i == 2'd0 && !flush_i) |=> (count_q == '0));

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
   parameter int unsigned DEPTH      = 6,
   parameter int unsigned AW         = 16,
   parameter logic [AW-1:0] RESET_ADDR = '0,
   localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush_i,
   input  logic [AW-1:0] flush_addr_i,
   input  logic          bus_idle_i,
   input  logic          ack_i,
   input  logic          rvalid_i,
   input  logic [15:0]   rdata_i,
   input  logic [CW-1:0] count_i,
   output logic          req_o,
   output logic [AW-1:0] addr_o,
   output logic [1:0]    wr_n_o,
   output logic [7:0]    wr_b0_o,
   output logic [7:0]    wr_b1_o
);

   logic [AW-1:0] ptr_q;
   logic          busy_q;
   logic          stale_q;
   logic          land;
   logic          room;

   initial begin
      assert (AW >= 2) else $error("pfq_fetch: AW must be at least 2");
      assert (DEPTH >= 2) else $error("pfq_fetch: DEPTH must be at least 2");
   end

   assign room   = count_i <= CW'(DEPTH - 2);
   assign req_o  = bus_idle_i && !busy_q && !flush_i && room;
   assign addr_o = {ptr_q[AW-1:1], 1'b0};
   assign land   = rvalid_i && busy_q && !stale_q && !flush_i;

   always_comb begin
      wr_n_o  = 2'd0;
      wr_b0_o = rdata_i[7:0];
      wr_b1_o = rdata_i[15:8];
      if (land) begin
         if (ptr_q[0]) begin
            wr_n_o  = 2'd1;
            wr_b0_o = rdata_i[15:8];
         end else begin
            wr_n_o  = 2'd2;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q   <= RESET_ADDR;
         busy_q  <= 1'b0;
         stale_q <= 1'b0;
      end else if (flush_i) begin
         ptr_q   <= flush_addr_i;
         busy_q  <= busy_q && !rvalid_i;
         stale_q <= busy_q && !rvalid_i;
      end else begin
         if (rvalid_i && busy_q) begin
            busy_q  <= 1'b0;
            stale_q <= 1'b0;
         end
         if (land) begin
            ptr_q <= ptr_q + AW'(wr_n_o);
         end
         if (req_o && ack_i) begin
            busy_q <= 1'b1;
         end
      end
   end

   a_r10_one_in_flight: assert property (@(posedge clk) disable iff (rst)
      (req_o && ack_i) |=> !req_o);

   a_r5_odd_step: assert property (@(posedge clk) disable iff (rst)
      (land && ptr_q[0]) |=> (ptr_q == $past(ptr_q) + AW'(1)));

endmodule

// File: rtl/pfq_status.sv
module pfq_status
   import pfq_pkg::*;
(
   input  logic flush_i,
   input  logic pop_ok_i,
   input  logic first_i,
   output qs_e  qs_o
);

   always_comb begin
      if (flush_i) begin
         qs_o = QS_FLUSH;
      end else if (pop_ok_i) begin
         qs_o = first_i ? QS_FIRST : QS_NEXT;
      end else begin
         qs_o = QS_IDLE;
      end
   end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
   import pfq_pkg::*;
#(
   parameter int unsigned   DEPTH      = 6,
   parameter int unsigned   AW         = 16,
   parameter logic [AW-1:0] RESET_ADDR = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush_i,
   input  logic [AW-1:0] flush_addr_i,
   input  logic          bus_idle_i,
   output logic          fetch_req_o,
   output logic [AW-1:0] fetch_addr_o,
   input  logic          fetch_ack_i,
   input  logic          fetch_rvalid_i,
   input  logic [15:0]   fetch_rdata_i,
   input  logic          rd_i,
   input  logic          rd_first_i,
   output logic          rd_valid_o,
   output logic [7:0]    rd_data_o,
   output logic [1:0]    qs_o
);

   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] count;
   logic [1:0]    wr_n;
   logic [7:0]    wr_b0, wr_b1;
   logic          pop_ok;
   qs_e           qs;

   initial begin
      assert (LANES == 2) else $error("prefetch_queue: fetch word must carry two bytes");
   end

   pfq_fetch #(.DEPTH(DEPTH), .AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
      .clk          (clk),
      .rst          (rst),
      .flush_i      (flush_i),
      .flush_addr_i (flush_addr_i),
      .bus_idle_i   (bus_idle_i),
      .ack_i        (fetch_ack_i),
      .rvalid_i     (fetch_rvalid_i),
      .rdata_i      (fetch_rdata_i),
      .count_i      (count),
      .req_o        (fetch_req_o),
      .addr_o       (fetch_addr_o),
      .wr_n_o       (wr_n),
      .wr_b0_o      (wr_b0),
      .wr_b1_o      (wr_b1)
   );

   pfq_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst      (rst),
      .flush_i  (flush_i),
      .pop_i    (rd_i),
      .wr_n_i   (wr_n),
      .wr_b0_i  (wr_b0),
      .wr_b1_i  (wr_b1),
      .count_o  (count),
      .pop_ok_o (pop_ok),
      .head_o   (rd_data_o)
   );

   pfq_status u_status (
      .flush_i  (flush_i),
      .pop_ok_i (pop_ok),
      .first_i  (rd_first_i),
      .qs_o     (qs)
   );

   assign qs_o       = qs;
   assign rd_valid_o = count != '0;

   a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
      flush_i |=> !rd_valid_o);

   a_r8_stale_dropped: assert property (@(posedge clk) disable iff (rst)
      (u_fetch.stale_q && fetch_rvalid_i) |=> (count <= $past(count)));

endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 6;

   logic        clk = 1'b0;
   logic        rst;
   logic        flush_i;
   logic [15:0] flush_addr_i;
   logic        bus_idle_i;
   logic        fetch_req_o;
   logic [15:0] fetch_addr_o;
   logic        fetch_ack_i;
   logic        fetch_rvalid_i;
   logic [15:0] fetch_rdata_i;
   logic        rd_i;
   logic        rd_first_i;
   logic        rd_valid_o;
   logic [7:0]  rd_data_o;
   logic [1:0]  qs_o;

   int total = 0;
   int bad   = 0;

   // behavioural model state
   logic [7:0]  q[$];
   logic [15:0] m_ptr;
   bit          m_stale;
   bit          bus_busy;
   int          bus_lat;
   logic [15:0] bus_addr;
   int          lat_cfg;
   bit          rand_lat;

   // last sampled outputs
   logic        s_req, s_valid;
   logic [15:0] s_addr;
   logic [7:0]  s_data;
   logic [1:0]  s_qs;

   always #(CLK_PERIOD / 2) clk = ~clk;

   prefetch_queue u_prefetch_queue (
      .clk            (clk),
      .rst            (rst),
      .flush_i        (flush_i),
      .flush_addr_i   (flush_addr_i),
      .bus_idle_i     (bus_idle_i),
      .fetch_req_o    (fetch_req_o),
      .fetch_addr_o   (fetch_addr_o),
      .fetch_ack_i    (fetch_ack_i),
      .fetch_rvalid_i (fetch_rvalid_i),
      .fetch_rdata_i  (fetch_rdata_i),
      .rd_i           (rd_i),
      .rd_first_i     (rd_first_i),
      .rd_valid_o     (rd_valid_o),
      .rd_data_o      (rd_data_o),
      .qs_o           (qs_o)
   );

   function automatic logic [7:0] mb(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle(input bit f, input logic [15:0] fa, input bit r, input bit fi,
                        input bit id, input bit ak);
      bit          ret, acc, e_req, e_valid;
      logic [1:0]  e_qs;
      @(negedge clk);
      flush_i      = f;
      flush_addr_i = fa;
      rd_i         = r;
      rd_first_i   = fi;
      bus_idle_i   = id;
      fetch_ack_i  = ak;
      ret = 1'b0;
      if (bus_busy) begin
         if (bus_lat == 0) ret = 1'b1;
         else bus_lat--;
      end
      fetch_rvalid_i = ret;
      fetch_rdata_i  = ret ? {mb(bus_addr | 16'h1), mb(bus_addr & 16'hFFFE)} : 16'h0;
      #1;
      s_req = fetch_req_o; s_addr = fetch_addr_o; s_valid = rd_valid_o;
      s_data = rd_data_o;  s_qs = qs_o;
      e_valid = q.size() > 0;
      e_req   = id && !bus_busy && (DEPTH - q.size() >= 2) && !f;
      e_qs    = f ? 2'b10 : ((r && e_valid) ? (fi ? 2'b01 : 2'b11) : 2'b00);
      check(s_req == e_req, "R2 fetch_req", s_req, e_req);
      if (e_req) check(s_addr == {m_ptr[15:1], 1'b0}, "R2 fetch_addr", s_addr, {m_ptr[15:1], 1'b0});
      check(s_valid == e_valid, "R4 rd_valid", s_valid, e_valid);
      if (e_valid) check(s_data == q[0], "R4 rd_data order", s_data, q[0]);
      check(s_qs == e_qs, "R6 qs code", s_qs, e_qs);
      // model update for the coming edge
      acc = e_req && ak;
      if (f) begin
         q.delete();
         m_ptr = fa;
         m_stale = bus_busy && !ret;
      end else begin
         if (r && e_valid) void'(q.pop_front());
         if (ret && !m_stale) begin
            if (m_ptr[0]) begin
               q.push_back(mb(m_ptr));
               m_ptr = m_ptr + 16'd1;
            end else begin
               q.push_back(mb(m_ptr));
               q.push_back(mb(m_ptr + 16'd1));
               m_ptr = m_ptr + 16'd2;
            end
         end
         if (ret) m_stale = 1'b0;
      end
      if (ret) bus_busy = 1'b0;
      if (acc) begin
         bus_busy = 1'b1;
         bus_lat  = rand_lat ? int'($urandom % 3) : lat_cfg;
         bus_addr = {m_ptr[15:1], 1'b0};
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; flush_i = 0; flush_addr_i = 0; rd_i = 0; rd_first_i = 0;
      bus_idle_i = 0; fetch_ack_i = 0; fetch_rvalid_i = 0; fetch_rdata_i = 0;
      m_ptr = 16'h0; m_stale = 0; bus_busy = 0; bus_lat = 0; bus_addr = 0;
      lat_cfg = 0; rand_lat = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1: reset state
      cycle(0, 0, 1, 1, 0, 0);
      check(s_valid == 0 && s_qs == 2'b00 && s_req == 0, "R1 reset empty", {s_valid, s_qs}, 0);
      cycle(0, 0, 0, 0, 1, 0);
      check(s_req == 1 && s_addr == 16'h0, "R1 reset offset", s_addr, 0);

      // R3: fill with no reads, queue stops at DEPTH
      for (int i = 0; i < 20; i++) cycle(0, 0, 0, 0, 1, 1);
      check(s_req == 0, "R3 no request when full", s_req, 0);
      check(q.size() == DEPTH, "R3 model full", q.size(), DEPTH);
      // R4 / R6: drain in order, first then subsequent bytes
      for (int i = 0; i < DEPTH; i++) begin
         cycle(0, 0, 1, (i == 0), 0, 0);
         check(s_data == mb(16'(i)), "R4 byte order", s_data, mb(16'(i)));
         check(s_qs == ((i == 0) ? 2'b01 : 2'b11), "R6 status on read", s_qs, (i == 0) ? 1 : 3);
      end
      // R9: read while empty
      cycle(0, 0, 1, 1, 0, 0);
      check(s_qs == 2'b00 && s_valid == 0, "R9 empty read ignored", s_qs, 0);
      cycle(0, 0, 0, 0, 0, 0);
      check(s_valid == 0, "R9 still empty", s_valid, 0);

      // R5: odd target keeps only the upper byte first
      cycle(1, 16'h0201, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 1, 1);
      check(s_valid && s_data == mb(16'h0201), "R5 odd first byte", s_data, mb(16'h0201));
      cycle(0, 0, 1, 1, 0, 0);
      cycle(0, 0, 0, 0, 0, 0);
      check(s_data == mb(16'h0202), "R5 next after odd", s_data, mb(16'h0202));

      // R7: flush and read together
      cycle(1, 16'h0340, 1, 1, 0, 0);
      check(s_qs == 2'b10, "R7 flush wins status", s_qs, 2);
      cycle(0, 0, 0, 0, 0, 0);
      check(s_valid == 0, "R7 empty after flush", s_valid, 0);

      // R8 / R10: flush while a long fetch is in flight
      lat_cfg = 3;
      cycle(0, 0, 0, 0, 1, 1);
      cycle(0, 0, 0, 0, 1, 1);
      check(s_req == 0, "R10 one fetch in flight", s_req, 0);
      cycle(1, 16'h0500, 0, 0, 0, 0);
      for (int i = 0; i < 5; i++) cycle(0, 0, 0, 0, 0, 0);
      check(s_valid == 0, "R8 stale word dropped", s_valid, 0);
      lat_cfg = 0;
      for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 1, 1);
      check(s_valid && s_data == mb(16'h0500), "R8 refetch from target", s_data, mb(16'h0500));
      // R8: flush in the same cycle as the return
      lat_cfg = 1;
      cycle(1, 16'h0600, 0, 0, 0, 0);
      cycle(0, 0, 0, 0, 1, 1);
      cycle(0, 0, 0, 0, 0, 0);
      cycle(1, 16'h0700, 0, 0, 0, 0);
      cycle(0, 0, 0, 0, 0, 0);
      check(s_valid == 0, "R8 return on flush cycle dropped", s_valid, 0);

      // random phase, model compared each cycle
      rand_lat = 1;
      for (int i = 0; i < 4000; i++) begin
         bit f;
         f = ($urandom % 23) == 0;
         cycle(f, 16'($urandom), ($urandom % 3) != 0, ($urandom % 2) == 0,
               ($urandom % 5) != 0, ($urandom % 4) != 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule